// File: doc/BRIEF.md
# Multi-Class Register Rename Table

This block holds the speculative mapping from architectural to physical registers for an out-of-order core. The core has three renamed register classes (integer, floating-point, condition-code) plus a set of miscellaneous registers that are never renamed. The caller gives one flattened architectural index. The block splits that index into a class and an offset within the class, then acts on that class's own map table and free-register FIFO.

Three operations are accepted, at most one per cycle:
- **rename** pops a fresh physical register for the destination and reports both the new and the displaced mapping.
- **lookup** reads the current mapping without changing anything.
- **set-entry** writes a chosen mapping, so that a squash can roll the table back.

A separate release port returns freed physical registers to the tail of their class FIFO. The policy that decides when to free is outside the block. The block also reports a conservative free count: the smaller of the integer and floating-point free counts.

Top module: `rename_table`

## Requirements
- R1: After reset, architectural register i of each renamed class maps to physical register class_base + i. The class bases are integer 0, floating-point 16 and condition-code 32. The class's remaining physical registers sit in its free FIFO in ascending order.
- R2: The flat index decodes as follows: integer [0,8), floating-point [8,16), condition-code [16,20), misc [20,24). Any operation on an index of 24 or above does nothing: no response and no stall. Op code 0 is idle.
- R3: Rename (op code 1) on a renamed class takes the head of that class's free FIFO. One cycle later it raises rsp_valid_o with rsp_new_o set to that register and rsp_prev_o set to the old mapping. Later lookups return the new register.
- R4: Integer register 0 is read-only. A rename of it answers with its current mapping as both new and prev, consumes no free register and leaves the map unchanged. The other classes have no such register.
- R5: Misc register k always resolves to physical index 40 + k. Rename and lookup of a misc register return that index as both new and prev, and change nothing.
- R6: Set-entry (op code 3) writes phys_i into the map of a renamed class, but only when phys_i lies inside that class's physical range. Otherwise, and for misc or invalid indices, it has no effect. Set-entry never produces a response.
- R7: A rename on a class whose free FIFO is empty raises stall_o in the same cycle. That rename produces no response and changes neither the map nor any count.
- R8: free_cnt_o equals the minimum of the integer and floating-point free-FIFO occupancies. Its reset value is 8.
- R9: A release places rel_phys_i at the tail of the FIFO of the class whose physical range contains it. Later renames hand registers out in FIFO order. A release into a full FIFO is dropped. A release of an index outside every class range is ignored.
- R10: Every physical index that rename or lookup returns for a renamed class lies inside that class's physical range.
- R11: Lookup (op code 2) answers one cycle later with the current mapping on both rsp_new_o and rsp_prev_o, and leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 2 | Operation: 0 idle, 1 rename, 2 lookup, 3 set-entry |
| arch_i | input | 5 | Flat architectural register index |
| phys_i | input | 6 | Physical register for set-entry |
| rel_valid_i | input | 1 | Release strobe |
| rel_phys_i | input | 6 | Physical register being released |
| stall_o | output | 1 | Rename refused: class free FIFO empty |
| rsp_valid_o | output | 1 | Registered response valid |
| rsp_new_o | output | 6 | New (or current) mapping |
| rsp_prev_o | output | 6 | Previous mapping |
| free_cnt_o | output | 4 | Min of integer and floating-point free counts |

## Verification
The bench first sweeps lookups across all 32 flat indices. This separates the four class windows, the misc offset and the invalid range, and confirms the reset mappings.

Directed sequences then cover the following:
- The read-only register and the misc pass-through, which tell whether the free FIFO is touched at all.
- Draining the integer and condition-code FIFOs until they stall, which exposes the empty boundary.
- A refill through the release port, which shows FIFO order and wrap-around.
- Set-entry with in-class and out-of-class physical values, which shows the range guard.

A long pseudo-random mix of all operations and releases, compared against an arithmetic model, then catches interactions between classes.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int NCLS = 3;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_RENAME = 2'd1,
    OP_LOOKUP = 2'd2,
    OP_SET    = 2'd3
  } rn_op_e;

  typedef enum logic [2:0] {
    CLS_INT  = 3'd0,
    CLS_FP   = 3'd1,
    CLS_CC   = 3'd2,
    CLS_MISC = 3'd3,
    CLS_NONE = 3'd4
  } rn_cls_e;
endpackage

// File: rtl/rn_class_decode.sv
module rn_class_decode
  import rn_pkg::*;
#(
  parameter int INT_N  = 8,
  parameter int FP_N   = 8,
  parameter int CC_N   = 4,
  parameter int MISC_N = 4,
  parameter int A_W    = 5
) (
  input  logic [A_W-1:0] arch_i,
  output rn_cls_e        cls_o,
  output logic [A_W-1:0] rel_o
);
  localparam int FP_LO   = INT_N;
  localparam int CC_LO   = FP_LO + FP_N;
  localparam int MISC_LO = CC_LO + CC_N;
  localparam int END_IDX = MISC_LO + MISC_N;

  always_comb begin
    cls_o = CLS_NONE;
    rel_o = '0;
    if (int'(arch_i) < FP_LO) begin
      cls_o = CLS_INT;
      rel_o = arch_i;
    end else if (int'(arch_i) < CC_LO) begin
      cls_o = CLS_FP;
      rel_o = arch_i - A_W'(FP_LO);
    end else if (int'(arch_i) < MISC_LO) begin
      cls_o = CLS_CC;
      rel_o = arch_i - A_W'(CC_LO);
    end else if (int'(arch_i) < END_IDX) begin
      cls_o = CLS_MISC;
      rel_o = arch_i - A_W'(MISC_LO);
    end
  end
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int ARCH_N = 8,
  parameter int A_W    = 5,
  parameter int P_W    = 6,
  parameter int BASE   = 0,
  localparam int IW    = (ARCH_N > 1) ? $clog2(ARCH_N) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [A_W-1:0] widx_i,
  input  logic [P_W-1:0] wdata_i,
  input  logic [A_W-1:0] ridx_i,
  output logic [P_W-1:0] rdata_o
);
  logic [P_W-1:0] map_q [ARCH_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ARCH_N; i++) map_q[i] <= P_W'(BASE + i);
    end else if (we_i && (int'(widx_i) < ARCH_N)) begin
      map_q[widx_i[IW-1:0]] <= wdata_i;
    end
  end

  assign rdata_o = (int'(ridx_i) < ARCH_N) ? map_q[ridx_i[IW-1:0]] : '0;
endmodule

// File: rtl/rn_free_fifo.sv
module rn_free_fifo #(
  parameter int DEPTH = 8,
  parameter int P_W   = 6,
  parameter int FIRST = 8,
  parameter int CW    = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pop_i,
  input  logic           push_i,
  input  logic [P_W-1:0] push_data_i,
  output logic [P_W-1:0] head_o,
  output logic [CW-1:0]  count_o
);
  logic [P_W-1:0]   mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CW-1:0]    cnt_q;
  logic             full, empty, do_pop, do_push;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_pop  = pop_i && !empty;
  assign do_push = push_i && (!full || do_pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= P_W'(FIRST + k);
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= CW'(DEPTH);
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= push_data_i;
        wr_q        <= nxt(wr_q);
      end
      if (do_pop) rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/rename_table.sv
module rename_table
  import rn_pkg::*;
#(
  parameter int INT_ARCH  = 8,
  parameter int FP_ARCH   = 8,
  parameter int CC_ARCH   = 4,
  parameter int MISC_ARCH = 4,
  parameter int INT_PHYS  = 16,
  parameter int FP_PHYS   = 16,
  parameter int CC_PHYS   = 8,
  parameter int INT_ZERO  = 0,
  parameter int FP_ZERO   = FP_ARCH,
  parameter int CC_ZERO   = CC_ARCH,
  localparam int MISC_LO  = INT_ARCH + FP_ARCH + CC_ARCH,
  localparam int ARCH_TOT = MISC_LO + MISC_ARCH,
  localparam int FP_BASE  = INT_PHYS,
  localparam int CC_BASE  = INT_PHYS + FP_PHYS,
  localparam int PHYS_TOT = CC_BASE + CC_PHYS,
  localparam int A_W      = $clog2(ARCH_TOT),
  localparam int P_W      = $clog2(PHYS_TOT + MISC_ARCH),
  localparam int D_INT    = INT_PHYS - INT_ARCH,
  localparam int D_FP     = FP_PHYS - FP_ARCH,
  localparam int D_CC     = CC_PHYS - CC_ARCH,
  localparam int MAX_FREE = (D_INT > D_FP) ? ((D_INT > D_CC) ? D_INT : D_CC)
                                           : ((D_FP > D_CC) ? D_FP : D_CC),
  localparam int CW       = $clog2(MAX_FREE + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [1:0]     op_i,
  input  logic [A_W-1:0] arch_i,
  input  logic [P_W-1:0] phys_i,
  input  logic           rel_valid_i,
  input  logic [P_W-1:0] rel_phys_i,
  output logic           stall_o,
  output logic           rsp_valid_o,
  output logic [P_W-1:0] rsp_new_o,
  output logic [P_W-1:0] rsp_prev_o,
  output logic [CW-1:0]  free_cnt_o
);
  rn_op_e         op;
  rn_cls_e        cls;
  logic [A_W-1:0] rel;

  logic [NCLS-1:0] hit, zero_hit, set_ok, rel_hit, we, empty;
  logic [P_W-1:0]  cur_map [NCLS];
  logic [P_W-1:0]  head    [NCLS];
  logic [P_W-1:0]  wdata   [NCLS];
  logic [CW-1:0]   cnt     [NCLS];

  logic           norm, is_misc, is_ren, ren_zero, ren_go, stall;
  logic [P_W-1:0] cur_sel, head_sel, misc_phys;
  logic           empty_sel, zero_sel;

  logic           rsp_valid_q;
  logic [P_W-1:0] rsp_new_q, rsp_prev_q;

  assign op = rn_op_e'(op_i);

  rn_class_decode #(
    .INT_N(INT_ARCH), .FP_N(FP_ARCH), .CC_N(CC_ARCH), .MISC_N(MISC_ARCH), .A_W(A_W)
  ) u_dec (
    .arch_i(arch_i),
    .cls_o (cls),
    .rel_o (rel)
  );

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    localparam int ARCH_N = (g == 0) ? INT_ARCH : (g == 1) ? FP_ARCH : CC_ARCH;
    localparam int PHYS_N = (g == 0) ? INT_PHYS : (g == 1) ? FP_PHYS : CC_PHYS;
    localparam int BASE   = (g == 0) ? 0 : (g == 1) ? FP_BASE : CC_BASE;
    localparam int ZERO   = (g == 0) ? INT_ZERO : (g == 1) ? FP_ZERO : CC_ZERO;

    assign hit[g]      = (cls == rn_cls_e'(3'(g)));
    assign zero_hit[g] = hit[g] && (int'(rel) == ZERO);
    assign set_ok[g]   = (op == OP_SET) && hit[g] &&
                         (int'(phys_i) >= BASE) && (int'(phys_i) < BASE + PHYS_N);
    assign rel_hit[g]  = rel_valid_i &&
                         (int'(rel_phys_i) >= BASE) && (int'(rel_phys_i) < BASE + PHYS_N);
    assign we[g]       = (ren_go && hit[g]) || set_ok[g];
    assign wdata[g]    = ren_go ? head[g] : phys_i;
    assign empty[g]    = (cnt[g] == '0);

    rn_map_table #(
      .ARCH_N(ARCH_N), .A_W(A_W), .P_W(P_W), .BASE(BASE)
    ) u_map (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (we[g]),
      .widx_i (rel),
      .wdata_i(wdata[g]),
      .ridx_i (rel),
      .rdata_o(cur_map[g])
    );

    rn_free_fifo #(
      .DEPTH(PHYS_N - ARCH_N), .P_W(P_W), .FIRST(BASE + ARCH_N), .CW(CW)
    ) u_free (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pop_i      (ren_go && hit[g]),
      .push_i     (rel_hit[g]),
      .push_data_i(rel_phys_i),
      .head_o     (head[g]),
      .count_o    (cnt[g])
    );
  end

  always_comb begin
    cur_sel   = '0;
    head_sel  = '0;
    empty_sel = 1'b0;
    zero_sel  = 1'b0;
    for (int g = 0; g < NCLS; g++) begin
      if (hit[g]) begin
        cur_sel   = cur_map[g];
        head_sel  = head[g];
        empty_sel = empty[g];
        zero_sel  = zero_hit[g];
      end
    end
  end

  assign norm      = |hit;
  assign is_misc   = (cls == CLS_MISC);
  assign misc_phys = P_W'(PHYS_TOT) + P_W'(rel);
  assign is_ren    = (op == OP_RENAME);
  assign ren_zero  = is_ren && norm && zero_sel;
  assign stall     = is_ren && norm && !zero_sel && empty_sel;
  assign ren_go    = is_ren && norm && !zero_sel && !empty_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_new_q   <= '0;
      rsp_prev_q  <= '0;
    end else begin
      rsp_valid_q <= ((is_ren || op == OP_LOOKUP) && (norm || is_misc)) && !stall;
      if (is_misc) begin
        rsp_new_q  <= misc_phys;
        rsp_prev_q <= misc_phys;
      end else if (norm && (is_ren || op == OP_LOOKUP)) begin
        rsp_new_q  <= ren_go ? head_sel : cur_sel;
        rsp_prev_q <= cur_sel;
      end
    end
  end

  assign stall_o     = stall;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_new_o   = rsp_new_q;
  assign rsp_prev_o  = rsp_prev_q;
  assign free_cnt_o  = (cnt[0] < cnt[1]) ? cnt[0] : cnt[1];
endmodule

// File: rtl/rename_table_chk.sv
module rename_table_chk #(
  parameter int A_W      = 5,
  parameter int P_W      = 6,
  parameter int CW       = 4,
  parameter int MISC_LO  = 20,
  parameter int ARCH_TOT = 24,
  parameter int PHYS_TOT = 40,
  parameter int MAX_FREE = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [1:0]     op_i,
  input logic [A_W-1:0] arch_i,
  input logic           rel_valid_i,
  input logic           stall_o,
  input logic           rsp_valid_o,
  input logic [P_W-1:0] rsp_new_o,
  input logic [P_W-1:0] rsp_prev_o,
  input logic [CW-1:0]  free_cnt_o
);
  p_stall_no_rsp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !rsp_valid_o);

  p_stall_keeps_cnt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !rel_valid_i) |=> $stable(free_cnt_o));

  p_ren_rsp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'd1 && int'(arch_i) < MISC_LO && !stall_o) |=> rsp_valid_o);

  p_lookup_same_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'd2 && int'(arch_i) < ARCH_TOT) |=> (rsp_valid_o && rsp_new_o == rsp_prev_o));

  p_misc_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'd1 && int'(arch_i) >= MISC_LO && int'(arch_i) < ARCH_TOT) |=>
      (rsp_valid_o && rsp_new_o == rsp_prev_o &&
       int'(rsp_new_o) == PHYS_TOT + int'($past(arch_i)) - MISC_LO));

  p_set_no_rsp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'd3) |=> !rsp_valid_o);

  p_bad_idx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(arch_i) >= ARCH_TOT) |-> !stall_o);

  p_cnt_no_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rel_valid_i |=> (free_cnt_o <= $past(free_cnt_o)));

  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(free_cnt_o) <= MAX_FREE);
endmodule

bind rename_table rename_table_chk #(
  .A_W(A_W), .P_W(P_W), .CW(CW), .MISC_LO(MISC_LO),
  .ARCH_TOT(ARCH_TOT), .PHYS_TOT(PHYS_TOT), .MAX_FREE(MAX_FREE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_i       (op_i),
  .arch_i     (arch_i),
  .rel_valid_i(rel_valid_i),
  .stall_o    (stall_o),
  .rsp_valid_o(rsp_valid_o),
  .rsp_new_o  (rsp_new_o),
  .rsp_prev_o (rsp_prev_o),
  .free_cnt_o (free_cnt_o)
);

// File: tb/sim_rename_table.sv
module sim_rename_table;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] op_i = '0;
  logic [4:0] arch_i = '0;
  logic [5:0] phys_i = '0;
  logic       rel_valid_i = 1'b0;
  logic [5:0] rel_phys_i = '0;
  logic       stall_o, rsp_valid_o;
  logic [5:0] rsp_new_o, rsp_prev_o;
  logic [3:0] free_cnt_o;

  always #10 clk_i = ~clk_i;

  rename_table u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .arch_i(arch_i), .phys_i(phys_i),
    .rel_valid_i(rel_valid_i), .rel_phys_i(rel_phys_i), .stall_o(stall_o),
    .rsp_valid_o(rsp_valid_o), .rsp_new_o(rsp_new_o), .rsp_prev_o(rsp_prev_o),
    .free_cnt_o(free_cnt_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int mm [20];
  int fq [3][16];
  int fh [3];
  int fc [3];
  int dep   [3] = '{8, 8, 4};
  int base  [3] = '{0, 16, 32};
  int nphys [3] = '{16, 16, 8};
  int lo    [4] = '{0, 8, 16, 20};

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic int dcls(int a);
    if (a < 8) return 0;
    if (a < 16) return 1;
    if (a < 20) return 2;
    if (a < 24) return 3;
    return 4;
  endfunction

  function automatic int pcls(int p);
    for (int c = 0; c < 3; c++)
      if (p >= base[c] && p < base[c] + nphys[c]) return c;
    return 3;
  endfunction

  function automatic int min_cnt();
    return (fc[0] < fc[1]) ? fc[0] : fc[1];
  endfunction

  task automatic do_op(int op, int a, int p, string tag);
    int c, r, es, ev, en, ep;
    c = dcls(a);
    r = (c < 4) ? a - lo[c] : 0;
    es = 0; ev = 0; en = 0; ep = 0;
    if (op == 1 && c < 4) begin
      if (c == 3) begin ev = 1; en = 40 + r; ep = en; end
      else if (c == 0 && r == 0) begin ev = 1; en = mm[a]; ep = en; end
      else if (fc[c] == 0) es = 1;
      else begin
        ev = 1; ep = mm[a]; en = fq[c][fh[c]];
        fh[c] = (fh[c] + 1) % dep[c]; fc[c]--; mm[a] = en;
      end
    end else if (op == 2 && c < 4) begin
      ev = 1; en = (c == 3) ? 40 + r : mm[a]; ep = en;
    end else if (op == 3 && c < 3) begin
      if (p >= base[c] && p < base[c] + nphys[c]) mm[a] = p;
    end
    @(negedge clk_i);
    op_i = 2'(op); arch_i = 5'(a); phys_i = 6'(p);
    #1 chk({tag, " R7 stall"}, int'(stall_o), es);
    @(posedge clk_i);
    @(negedge clk_i);
    op_i = '0;
    #1 chk({tag, " rsp_valid"}, int'(rsp_valid_o), ev);
    if (ev) begin
      chk({tag, " new"}, int'(rsp_new_o), en);
      chk({tag, " prev"}, int'(rsp_prev_o), ep);
      if (c < 3) chk({tag, " R10 range"},
                     int'(int'(rsp_new_o) >= base[c] && int'(rsp_new_o) < base[c] + nphys[c]), 1);
    end
    chk({tag, " R8 free_cnt"}, int'(free_cnt_o), min_cnt());
  endtask

  task automatic do_rel(int p, string tag);
    int c;
    c = pcls(p);
    if (c < 3 && fc[c] < dep[c]) begin
      fq[c][(fh[c] + fc[c]) % dep[c]] = p;
      fc[c]++;
    end
    @(negedge clk_i);
    rel_valid_i = 1'b1; rel_phys_i = 6'(p);
    @(posedge clk_i);
    @(negedge clk_i);
    rel_valid_i = 1'b0;
    #1 chk({tag, " free_cnt"}, int'(free_cnt_o), min_cnt());
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    bit [15:0] lf;
    for (int a = 0; a < 20; a++) mm[a] = (a < 8) ? a : (a < 16) ? 16 + a - 8 : 32 + a - 16;
    for (int c = 0; c < 3; c++) begin
      fh[c] = 0; fc[c] = dep[c];
      for (int k = 0; k < dep[c]; k++) fq[c][k] = base[c] + nphys[c] - dep[c] + k;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R8 reset free_cnt", int'(free_cnt_o), 8);
    chk("R1 reset stall", int'(stall_o), 0);
    chk("R1 reset rsp_valid", int'(rsp_valid_o), 0);

    for (int a = 0; a < 32; a++) do_op(2, a, 0, (a < 24) ? "R1 lookup" : "R2 bad index");

    do_op(1, 0, 0, "R4 zero rename");
    do_op(2, 0, 0, "R4 zero map");
    for (int a = 20; a < 24; a++) do_op(1, a, 0, "R5 misc rename");
    do_op(1, 25, 0, "R2 bad rename");

    for (int a = 1; a < 8; a++) begin
      do_op(1, a, 0, "R3 int rename");
      do_op(2, a, 0, "R11 lookup after rename");
    end
    do_op(1, 1, 0, "R3 last int");
    do_op(1, 2, 0, "R7 empty int");
    do_op(2, 2, 0, "R7 map kept");

    do_rel(9, "R9 release int");
    do_rel(45, "R9 release misc ignored");
    do_op(1, 2, 0, "R9 reuse released");
    do_op(1, 3, 0, "R7 empty again");

    for (int a = 8; a < 16; a++) do_op(1, a, 0, "R3 fp rename");
    for (int i = 0; i < 6; i++) do_op(1, 16 + (i % 4), 0, "R7 cc drain");

    do_op(3, 3, 5, "R6 set in range");
    do_op(2, 3, 0, "R6 lookup set");
    do_op(3, 3, 20, "R6 set out of class");
    do_op(2, 3, 0, "R6 lookup unchanged");
    do_op(3, 21, 5, "R6 set misc");
    do_op(2, 21, 0, "R6 misc unchanged");
    do_op(3, 17, 33, "R6 set cc");
    do_op(2, 17, 0, "R6 lookup cc");

    for (int p = 0; p < 16; p++) do_rel(p, "R9 fill int");
    for (int p = 16; p < 32; p++) do_rel(p, "R9 fill fp");
    for (int p = 32; p < 40; p++) do_rel(p, "R9 fill cc");
    for (int a = 1; a < 8; a++) do_op(1, a, 0, "R9 fifo order");

    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[2:0] == 3'd7) do_rel(int'(lf[15:10]) % 48, "R9 rand release");
      else do_op(int'(lf[1:0]), int'(lf[8:4]) % 26, int'(lf[15:10]) % 48, "R10 rand");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule